// File: doc/BRIEF.md
# Bit Manipulation and Shift Unit

This block executes the bit-and-shift instruction group of a 16-bit processor core. It takes a target register value, a 3-bit operation type and a 4-bit control field. When the control field names a register, it also takes that register's value. From these it produces the new target value, a register-file write enable and fresh N, Z and C flags. A start strobe captures the operands. The outputs appear one clock later, qualified by a one-cycle valid pulse.

Eight operations are available. The four bit operations are test, toggle, set and clear; each addresses one bit position. The four count operations are shift left, logical shift right, rotate left and rotate right. A select input chooses where the position or count comes from. It is either the 4-bit literal in the control field, or the low four bits of the register that field names. Decoding the instruction word, reading the register file and writing back the result are handled outside this block.

Top module: `bit_shift_unit`

## Requirements
- R1: The outputs are updated on the clock edge at which start_i is high, and valid_o is high for exactly that next cycle. On an edge with start_i low, valid_o goes low and result_o and the flags keep their values.
- R2: With dyn_i=0 the position or count is ctl_i. With dyn_i=1 it is ctl_reg_i[3:0], and ctl_reg_i[15:4] has no effect on any output.
- R3: Op 3'b000 (test) returns result_o equal to tgt_i and leaves wr_en_o low. flag_z_o is set when the selected bit of tgt_i is 0.
- R4: Ops 3'b001, 3'b010 and 3'b011 toggle, set and clear, in that order, bit n of tgt_i. They raise wr_en_o, and flag_z_o is the inverse of bit n before the change.
- R5: For ops 000 to 011, flag_n_o equals result_o[15] and flag_c_o is 0.
- R6: Op 3'b100 shifts left by n and fills with zeros. Op 3'b101 shifts right by n and fills with zeros.
- R7: Op 3'b110 rotates left by n and op 3'b111 rotates right by n. Both rotates wrap within 16 bits and do not pass through the carry.
- R8: For ops 100 to 111, flag_c_o is the last bit moved out of the word, and flag_n_o and flag_z_o describe result_o. Those ops raise wr_en_o.
- R9: A count of 0 on ops 100 to 111 returns tgt_i unchanged and clears flag_c_o.
- R10: While rst_ni is low, valid_o, wr_en_o, result_o and all flags are 0.
- R11: wr_en_o is never high while valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture operands and execute |
| tgt_i | input | 16 | Target register value |
| dyn_i | input | 1 | 0: count from ctl_i, 1: count from ctl_reg_i |
| op_i | input | 3 | Operation type |
| ctl_i | input | 4 | Literal position/count, or register index |
| ctl_reg_i | input | 16 | Value of the register named by ctl_i |
| valid_o | output | 1 | Result valid pulse |
| result_o | output | 16 | New target value |
| wr_en_o | output | 1 | Write result back to target register |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
Two things can happen in the same cycle: one result is presented while the next operation is captured. The bench keeps start_i high over the whole sweep to provoke this. Every combination of operation, count source and position 0 to 15 is applied over five target patterns. Each output is compared one cycle after its strobe against a bit-serial model, so a result that leaks into the following cycle, or a stale one, is caught. In dynamic mode ctl_i carries the complement of the count and ctl_reg_i carries noise in its upper bits, so taking the count from the wrong source shows up as a mismatch.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [2:0] {
    OP_TST = 3'b000,
    OP_TGL = 3'b001,
    OP_SET = 3'b010,
    OP_CLR = 3'b011,
    OP_SHL = 3'b100,
    OP_SHR = 3'b101,
    OP_ROL = 3'b110,
    OP_ROR = 3'b111
  } bsu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
  } bsu_flags_t;
endpackage

// File: rtl/bsu_bit_op.sv
module bsu_bit_op #(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [CNT_W-1:0]  pos_i,
  input  logic [1:0]        kind_i,
  output logic [DATA_W-1:0] res_o,
  output logic              z_o
);
  logic [DATA_W-1:0] mask;

  assign mask = DATA_W'(1) << pos_i;
  assign z_o  = ~|(val_i & mask);

  always_comb begin
    unique case (kind_i)
      2'b00:   res_o = val_i;
      2'b01:   res_o = val_i ^ mask;
      2'b10:   res_o = val_i | mask;
      default: res_o = val_i & ~mask;
    endcase
  end
endmodule

// File: rtl/bsu_shifter.sv
module bsu_shifter #(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              left_i,
  input  logic              rot_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o
);
  logic [DATA_W-1:0] stg [CNT_W+1];
  logic [CNT_W-1:0]  out_idx;

  assign stg[0] = val_i;

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int S = 2 ** k;
    logic [DATA_W-1:0] s_in, sh_l, sh_r;
    assign s_in = stg[k];
    assign sh_l = rot_i ? {s_in[DATA_W-1-S:0], s_in[DATA_W-1:DATA_W-S]}
                        : {s_in[DATA_W-1-S:0], {S{1'b0}}};
    assign sh_r = rot_i ? {s_in[S-1:0], s_in[DATA_W-1:S]}
                        : {{S{1'b0}}, s_in[DATA_W-1:S]};
    assign stg[k+1] = cnt_i[k] ? (left_i ? sh_l : sh_r) : s_in;
  end

  assign res_o = stg[CNT_W];

  // last bit out: left -> val[W-n] (== -n mod W), right -> val[n-1]
  assign out_idx = left_i ? (~cnt_i + 1'b1) : (cnt_i - 1'b1);
  assign c_o     = (cnt_i != '0) && val_i[out_idx];
endmodule

// File: rtl/bit_shift_unit.sv
module bit_shift_unit
  import bsu_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tgt_i,
  input  logic              dyn_i,
  input  logic [2:0]        op_i,
  input  logic [CNT_W-1:0]  ctl_i,
  input  logic [DATA_W-1:0] ctl_reg_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_c_o
);
  bsu_op_e           op;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] bit_res, shf_res, nxt_res;
  logic              bit_z, shf_c;
  bsu_flags_t        nxt_flg, flg_q;
  logic              unused_ctl_hi;

  assign op            = bsu_op_e'(op_i);
  assign cnt           = dyn_i ? ctl_reg_i[CNT_W-1:0] : ctl_i;
  assign unused_ctl_hi = ^ctl_reg_i[DATA_W-1:CNT_W];

  bsu_bit_op #(.DATA_W(DATA_W)) u_bit (
    .val_i (tgt_i),
    .pos_i (cnt),
    .kind_i(op_i[1:0]),
    .res_o (bit_res),
    .z_o   (bit_z)
  );

  bsu_shifter #(.DATA_W(DATA_W)) u_shf (
    .val_i (tgt_i),
    .cnt_i (cnt),
    .left_i(~op_i[0]),
    .rot_i (op_i[1]),
    .res_o (shf_res),
    .c_o   (shf_c)
  );

  always_comb begin
    if (op_i[2]) begin
      nxt_res   = shf_res;
      nxt_flg.c = shf_c;
      nxt_flg.z = (shf_res == '0);
    end else begin
      nxt_res   = bit_res;
      nxt_flg.c = 1'b0;
      nxt_flg.z = bit_z;
    end
    nxt_flg.n = nxt_res[DATA_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      result_o <= '0;
      flg_q    <= '0;
    end else if (start_i) begin
      valid_o  <= 1'b1;
      wr_en_o  <= (op != OP_TST);
      result_o <= nxt_res;
      flg_q    <= nxt_flg;
    end else begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
    end
  end

  assign flag_n_o = flg_q.n;
  assign flag_z_o = flg_q.z;
  assign flag_c_o = flg_q.c;
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] tgt_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              valid_o,
  input logic              wr_en_o,
  input logic [DATA_W-1:0] result_o,
  input logic              flag_n_o,
  input logic              flag_z_o,
  input logic              flag_c_o
);
  p_valid_after_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  p_hold_when_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!valid_o && $stable(result_o) && $stable(flag_z_o)));

  p_test_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'b000) |=> (!wr_en_o && result_o == $past(tgt_i)));

  p_bit_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !op_i[2]) |=> (!flag_c_o && flag_n_o == result_o[DATA_W-1]));

  p_shift_nz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i[2]) |=> (wr_en_o && flag_z_o == (result_o == '0)
                              && flag_n_o == result_o[DATA_W-1]));

  p_zero_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i[2] && cnt_i == '0) |=> (result_o == $past(tgt_i) && !flag_c_o));

  p_write_needs_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> valid_o);
endmodule

bind bit_shift_unit bsu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_i    (op_i),
  .tgt_i   (tgt_i),
  .cnt_i   (cnt),
  .valid_o (valid_o),
  .wr_en_o (wr_en_o),
  .result_o(result_o),
  .flag_n_o(flag_n_o),
  .flag_z_o(flag_z_o),
  .flag_c_o(flag_c_o)
);

// File: tb/tb_bit_shift_unit.sv
module tb_bit_shift_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] tgt_i = '0;
  logic        dyn_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [3:0]  ctl_i = '0;
  logic [15:0] ctl_reg_i = '0;
  logic        valid_o, wr_en_o, flag_n_o, flag_z_o, flag_c_o;
  logic [15:0] result_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bit_shift_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .tgt_i(tgt_i),
    .dyn_i(dyn_i), .op_i(op_i), .ctl_i(ctl_i), .ctl_reg_i(ctl_reg_i),
    .valid_o(valid_o), .result_o(result_o), .wr_en_o(wr_en_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bit-serial reference
  task automatic model(input logic [2:0] op, input logic [15:0] t, input logic [3:0] n,
                       output logic [15:0] r, output logic we, output logic nf,
                       output logic zf, output logic cf);
    r = t;
    cf = 1'b0;
    if (!op[2]) begin
      zf = !t[n];
      case (op[1:0])
        2'b01: r[n] = ~r[n];
        2'b10: r[n] = 1'b1;
        2'b11: r[n] = 1'b0;
        default: ;
      endcase
      we = (op != 3'b000);
    end else begin
      for (int i = 0; i < int'(n); i++) begin
        case (op[1:0])
          2'b00: begin cf = r[15]; r = {r[14:0], 1'b0}; end
          2'b01: begin cf = r[0];  r = {1'b0, r[15:1]}; end
          2'b10: begin cf = r[15]; r = {r[14:0], r[15]}; end
          default: begin cf = r[0]; r = {r[0], r[15:1]}; end
        endcase
      end
      zf = (r == '0);
      we = 1'b1;
    end
    nf = r[15];
  endtask

  function automatic logic [15:0] pattern(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8001;
      3: return 16'hA5C3;
      default: return 16'h1234;
    endcase
  endfunction

  logic        p_pend = 1'b0;
  logic [15:0] p_r;
  logic        p_we, p_n, p_z, p_c;
  string       p_tag, p_ftag;

  task automatic check_pending();
    check(valid_o === 1'b1, "R1", "valid", {15'd0, valid_o}, 16'd1);
    check(result_o === p_r, p_tag, "result", result_o, p_r);
    check(wr_en_o === p_we, p_tag, "wr_en", {15'd0, wr_en_o}, {15'd0, p_we});
    check(flag_z_o === p_z, p_ftag, "flag_z", {15'd0, flag_z_o}, {15'd0, p_z});
    check(flag_n_o === p_n, p_ftag, "flag_n", {15'd0, flag_n_o}, {15'd0, p_n});
    check(flag_c_o === p_c, p_ftag, "flag_c", {15'd0, flag_c_o}, {15'd0, p_c});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check(valid_o === 1'b0 && wr_en_o === 1'b0, "R10", "valid/wr_en", {14'd0, valid_o, wr_en_o}, 16'd0);
    check(result_o === 16'h0000, "R10", "result", result_o, 16'h0000);
    check({flag_n_o, flag_z_o, flag_c_o} === 3'b000, "R10", "flags",
          {13'd0, flag_n_o, flag_z_o, flag_c_o}, 16'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // back-to-back sweep: one result checked while the next is captured
    for (int op = 0; op < 8; op++) begin
      for (int dy = 0; dy < 2; dy++) begin
        for (int n = 0; n < 16; n++) begin
          for (int ti = 0; ti < 5; ti++) begin
            @(negedge clk_i);
            if (p_pend) check_pending();
            start_i = 1'b1;
            op_i    = 3'(op);
            dyn_i   = 1'(dy);
            tgt_i   = pattern(ti) ^ 16'(n * 16'h0111);
            if (dy != 0) begin
              ctl_i     = ~4'(n);
              ctl_reg_i = {12'(16'hB6D * (ti + 1)), 4'(n)};
            end else begin
              ctl_i     = 4'(n);
              ctl_reg_i = {12'hFFF, ~4'(n)};
            end
            model(3'(op), tgt_i, 4'(n), p_r, p_we, p_n, p_z, p_c);
            if (op == 0)      p_tag = "R3";
            else if (op < 4)  p_tag = "R4";
            else if (op < 6)  p_tag = "R6";
            else              p_tag = "R7";
            if (op >= 4 && n == 0) p_tag = "R9";
            else if (dy != 0)      p_tag = "R2";
            p_ftag = (op < 4) ? ((op == 0) ? "R3/R5" : "R4/R5") : "R8";
            p_pend = 1'b1;
          end
        end
      end
    end
    @(negedge clk_i);
    check_pending();
    start_i = 1'b0;
    tgt_i   = 16'hDEAD;
    op_i    = 3'b001;
    @(negedge clk_i);
    check(valid_o === 1'b0, "R1", "valid idle", {15'd0, valid_o}, 16'd0);
    check(result_o === p_r, "R1", "result held", result_o, p_r);
    check(flag_z_o === p_z, "R1", "flag_z held", {15'd0, flag_z_o}, {15'd0, p_z});
    check(wr_en_o === 1'b0, "R11", "wr_en idle", {15'd0, wr_en_o}, 16'd0);
    @(negedge clk_i);
    check(wr_en_o === 1'b0 && valid_o === 1'b0, "R11", "wr_en idle 2", {14'd0, valid_o, wr_en_o}, 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule